// File: doc/BRIEF.md
# Receive Packet Queue with Non-Posted Bypass

This block sits between a link receive path and user logic. It takes in transaction packets made of 32-bit words, each packet tagged as posted, non-posted or completion. It stores every packet in full before it offers that packet on a framed valid/ready output. The output carries start and end markers, a poison flag that appears on the last word, and a 7-bit region-hit vector that stays with the packet.

Each class has its own word store and packet slots. An age stamp on every complete packet lets the output pick packets in arrival order. When the user lowers its non-posted-ok input, waiting non-posted packets are held back and younger posted and completion packets go first. The block reports the free header and data room of each class at every cycle. A link-reset input empties all three classes at once and flags any packet that was being offered as discontinued.

Top module: `rx_pkt_queue`

## Requirements
- R1: `out_valid_o` rises for a packet only after the input has accepted that packet's end word. While a packet is still arriving it is never offered.
- R2: The first word of each delivered packet has `out_sof_o` set and the last has `out_eof_o` set. A word moves only in a cycle where `out_valid_o` and `out_ready_i` are both high. While ready is low, the offered word and its markers hold.
- R3: `out_poison_o` is high only on the end word of a packet. It is high there exactly when `in_poison_i` was high on any accepted word of that packet.
- R4: The 7-bit `in_hit_i` value sampled on a packet's start word is presented unchanged on `out_hit_o` for every word of that packet. Bits 0 to 5 are the six address regions and bit 6 is the expansion-ROM region. A packet that hits a 64-bit region pair carries both bits.
- R5: Packets of one class leave in arrival order. While `np_ok_i` is high, packets of all classes leave in the order their end words arrived, so a completion never overtakes an older posted packet.
- R6: When a new packet is chosen while `np_ok_i` is low, no non-posted packet is chosen. Queued posted and completion packets are delivered, and waiting non-posted packets stay queued until `np_ok_i` rises. A non-posted packet that has already been chosen completes.
- R7: Class codes on `in_class_i` and `out_class_o` are 2'b00 posted, 2'b01 non-posted and 2'b10 completion.
- R8: Each `*_hdr_free_o` equals the packet slots per class minus the packets of that class that are held. A packet is held from acceptance of its start word until its end word leaves the output.
- R9: Each `*_data_free_o` equals floor((words per class minus words held) / 4), so one credit is 4 words. The words of a packet are returned when its end word leaves.
- R10: While `link_reset_i` is high, `out_valid_o` is low, `in_ready_o` is low, and `out_dsc_o` is high if a packet had been chosen for delivery. The cycle after, all classes are empty and every credit output is at its full value.
- R11: `in_ready_o` is low while the addressed class has no free word, or, on a start word, no free packet slot. No word is lost while it is low.
- R12: After reset nothing is offered, the input is ready, and all credit outputs read full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_reset_i | input | 1 | Link going into reset: discard all content |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 32 | Input word |
| in_sof_i | input | 1 | First word of a packet |
| in_eof_i | input | 1 | Last word of a packet |
| in_poison_i | input | 1 | Poison mark, any word of the packet |
| in_class_i | input | 2 | Class code, sampled on the start word |
| in_hit_i | input | 7 | Region-hit vector, sampled on the start word |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | User accepts the output word |
| out_data_o | output | 32 | Output word |
| out_sof_o | output | 1 | First word of the offered packet |
| out_eof_o | output | 1 | Last word of the offered packet |
| out_poison_o | output | 1 | Poisoned packet, shown on the end word |
| out_hit_o | output | 7 | Region-hit vector of the offered packet |
| out_class_o | output | 2 | Class of the offered packet |
| out_dsc_o | output | 1 | Offered packet discontinued by link reset |
| np_ok_i | input | 1 | User can take non-posted packets |
| p_hdr_free_o | output | 8 | Free posted header credits |
| p_data_free_o | output | 12 | Free posted data credits |
| np_hdr_free_o | output | 8 | Free non-posted header credits |
| np_data_free_o | output | 12 | Free non-posted data credits |
| cpl_hdr_free_o | output | 8 | Free completion header credits |
| cpl_data_free_o | output | 12 | Free completion data credits |

## Verification
The bench builds the block with its defaults: 64 words and 8 packet slots per class. With these sizes, four 16-word posted packets fill a class exactly, so the stalled input and zero data credits can be reached in a few dozen cycles. Single-word packets exercise a start and end on one word, with poison on that same word. Holding the output stalled while mixed classes queue up brings arrival-order selection and the non-posted hold within reach. The same stall keeps a packet chosen but not yet taken when the link reset hits.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    CLS_P   = 2'd0,
    CLS_NP  = 2'd1,
    CLS_CPL = 2'd2
  } cls_e;

  localparam int NUM_CLS = 3;
  localparam int HIT_W   = 7;
endpackage

// File: rtl/rxq_class_buf.sv
module rxq_class_buf #(
  parameter int DEPTH     = 64,
  parameter int HDR_DEPTH = 8,
  parameter int DESC_W    = 16,
  parameter int DW        = 32,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int HAW = (HDR_DEPTH > 1) ? $clog2(HDR_DEPTH) : 1,
  localparam int HCW = $clog2(HDR_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              wr_eof_i,
  input  logic              hdr_take_i,
  input  logic              desc_push_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic              rd_en_i,
  input  logic [CW-1:0]     rel_words_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_eof_o,
  output logic [DESC_W-1:0] desc_o,
  output logic              desc_valid_o,
  output logic              word_space_o,
  output logic              hdr_space_o,
  output logic [7:0]        hdr_free_o,
  output logic [11:0]       data_free_o
);
  logic [DW:0]       mem_q  [DEPTH];
  logic [DESC_W-1:0] dmem_q [HDR_DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [HAW-1:0]    dwp_q, drp_q;
  logic [CW-1:0]     words_q;
  logic [HCW-1:0]    hdr_q, dcnt_q;
  logic              pop;

  function automatic logic [AW-1:0] inc_w(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [HAW-1:0] inc_d(input logic [HAW-1:0] p);
    return (p == HAW'(HDR_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_data_o    = mem_q[rptr_q][DW-1:0];
  assign rd_eof_o     = mem_q[rptr_q][DW];
  assign desc_o       = dmem_q[drp_q];
  assign desc_valid_o = (dcnt_q != '0);
  assign word_space_o = (words_q < CW'(DEPTH));
  assign hdr_space_o  = (hdr_q < HCW'(HDR_DEPTH));
  assign hdr_free_o   = 8'(HCW'(HDR_DEPTH) - hdr_q);
  assign data_free_o  = 12'((CW'(DEPTH) - words_q) >> 2);
  assign pop          = rd_en_i & rd_eof_o;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wptr_q] <= {wr_eof_i, wr_data_i};
    if (desc_push_i) dmem_q[dwp_q] <= desc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      dwp_q   <= '0;
      drp_q   <= '0;
      words_q <= '0;
      hdr_q   <= '0;
      dcnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      dwp_q   <= '0;
      drp_q   <= '0;
      words_q <= '0;
      hdr_q   <= '0;
      dcnt_q  <= '0;
    end else begin
      if (wr_en_i) wptr_q <= inc_w(wptr_q);
      if (rd_en_i) rptr_q <= inc_w(rptr_q);
      if (desc_push_i) dwp_q <= inc_d(dwp_q);
      if (pop) drp_q <= inc_d(drp_q);
      // words come back as a whole packet on its last word
      words_q <= words_q + CW'(wr_en_i) - (pop ? rel_words_i : '0);
      hdr_q   <= hdr_q + HCW'(hdr_take_i) - HCW'(pop);
      dcnt_q  <= dcnt_q + HCW'(desc_push_i) - HCW'(pop);
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) |-> (words_q < CW'(DEPTH)));
  a_r8_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_push_i && !flush_i) |-> (dcnt_q < HCW'(HDR_DEPTH)));
  a_r1_read_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> desc_valid_o);
endmodule

// File: rtl/rxq_arb.sv
module rxq_arb #(
  parameter int NC = 3,
  parameter int SW = 6
) (
  input  logic [NC-1:0] elig_i,
  input  logic [SW-1:0] stamp_i [NC],
  output logic [NC-1:0] grant_o
);
  // a is older than b when a - b wraps negative
  function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  for (genvar c = 0; c < NC; c++) begin : g_win
    logic win;
    always_comb begin
      win = elig_i[c];
      for (int d = 0; d < NC; d++) begin
        if (d != c && elig_i[d] && !older(stamp_i[c], stamp_i[d])) win = 1'b0;
      end
    end
    assign grant_o[c] = win;
  end
endmodule

// File: rtl/rx_pkt_queue.sv
module rx_pkt_queue #(
  parameter int WORDS_PER_CLS = 64,
  parameter int PKTS_PER_CLS  = 8,
  parameter int DW            = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_reset_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_sof_i,
  input  logic          in_eof_i,
  input  logic          in_poison_i,
  input  logic [1:0]    in_class_i,
  input  logic [6:0]    in_hit_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_sof_o,
  output logic          out_eof_o,
  output logic          out_poison_o,
  output logic [6:0]    out_hit_o,
  output logic [1:0]    out_class_o,
  output logic          out_dsc_o,
  input  logic          np_ok_i,
  output logic [7:0]    p_hdr_free_o,
  output logic [11:0]   p_data_free_o,
  output logic [7:0]    np_hdr_free_o,
  output logic [11:0]   np_data_free_o,
  output logic [7:0]    cpl_hdr_free_o,
  output logic [11:0]   cpl_data_free_o
);
  import rxq_pkg::*;

  localparam int NC = NUM_CLS;
  localparam int LW = $clog2(WORDS_PER_CLS + 1);
  localparam int SW = $clog2(NC * PKTS_PER_CLS) + 1;

  typedef struct packed {
    logic [SW-1:0]    stamp;
    logic [HIT_W-1:0] hit;
    logic             poison;
    logic [LW-1:0]    len;
  } desc_t;
  localparam int DESC_W = $bits(desc_t);

  logic              in_pkt_q, in_pois_q, busy_q, first_q;
  logic [1:0]        in_cls_q, sel_q, sel_d, cur_cls;
  logic [LW-1:0]     in_len_q;
  logic [HIT_W-1:0]  in_hit_q;
  logic [SW-1:0]     stamp_q;

  logic [NC-1:0]     wr_en, rd_en, desc_valid, word_space, hdr_space, elig, grant;
  logic [DW-1:0]     rd_data [NC];
  logic              rd_eof  [NC];
  logic [DESC_W-1:0] desc_rd [NC];
  logic [SW-1:0]     stamps  [NC];
  logic [7:0]        hdr_free [NC];
  logic [11:0]       data_free [NC];
  desc_t             desc_in, desc_sel;
  logic              in_acc, in_keep, in_new, xfer;

  assign cur_cls = in_pkt_q ? in_cls_q : in_class_i;
  assign in_new  = !in_pkt_q && in_sof_i;
  assign in_keep = in_pkt_q || in_sof_i;
  assign in_acc  = in_valid_i && in_ready_o;

  always_comb begin
    if (link_reset_i)   in_ready_o = 1'b0;
    else if (in_pkt_q)  in_ready_o = word_space[in_cls_q];
    else if (in_sof_i)  in_ready_o = (in_class_i != 2'd3) && word_space[in_class_i]
                                     && hdr_space[in_class_i];
    else                in_ready_o = 1'b1;  // stray word outside a packet is dropped
  end

  always_comb begin
    desc_in.stamp  = stamp_q;
    desc_in.hit    = in_new ? in_hit_i : in_hit_q;
    desc_in.poison = in_poison_i || (in_pkt_q && in_pois_q);
    desc_in.len    = (in_new ? '0 : in_len_q) + 1'b1;
  end

  for (genvar c = 0; c < NC; c++) begin : g_cls
    desc_t d_c;
    assign d_c       = desc_t'(desc_rd[c]);
    assign stamps[c] = d_c.stamp;
    assign wr_en[c]  = in_acc && in_keep && (cur_cls == 2'(c));
    assign rd_en[c]  = xfer && (sel_q == 2'(c));
    if (c == int'(CLS_NP)) begin : g_np
      assign elig[c] = desc_valid[c] && np_ok_i;
    end else begin : g_pc
      assign elig[c] = desc_valid[c];
    end

    rxq_class_buf #(
      .DEPTH(WORDS_PER_CLS), .HDR_DEPTH(PKTS_PER_CLS), .DESC_W(DESC_W), .DW(DW)
    ) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (link_reset_i),
      .wr_en_i     (wr_en[c]),
      .wr_data_i   (in_data_i),
      .wr_eof_i    (in_eof_i),
      .hdr_take_i  (wr_en[c] && in_new),
      .desc_push_i (wr_en[c] && in_eof_i),
      .desc_i      (desc_in),
      .rd_en_i     (rd_en[c]),
      .rel_words_i (d_c.len),
      .rd_data_o   (rd_data[c]),
      .rd_eof_o    (rd_eof[c]),
      .desc_o      (desc_rd[c]),
      .desc_valid_o(desc_valid[c]),
      .word_space_o(word_space[c]),
      .hdr_space_o (hdr_space[c]),
      .hdr_free_o  (hdr_free[c]),
      .data_free_o (data_free[c])
    );
  end

  rxq_arb #(.NC(NC), .SW(SW)) u_arb (
    .elig_i (elig),
    .stamp_i(stamps),
    .grant_o(grant)
  );

  always_comb begin
    sel_d = '0;
    for (int c = 0; c < NC; c++) if (grant[c]) sel_d = 2'(c);
  end

  assign desc_sel     = desc_t'(desc_rd[sel_q]);
  assign out_valid_o  = busy_q && !link_reset_i;
  assign xfer         = out_valid_o && out_ready_i;
  assign out_data_o   = rd_data[sel_q];
  assign out_eof_o    = rd_eof[sel_q];
  assign out_sof_o    = first_q;
  assign out_poison_o = rd_eof[sel_q] && desc_sel.poison;
  assign out_hit_o    = desc_sel.hit;
  assign out_class_o  = sel_q;
  assign out_dsc_o    = link_reset_i && busy_q;

  assign p_hdr_free_o    = hdr_free[CLS_P];
  assign p_data_free_o   = data_free[CLS_P];
  assign np_hdr_free_o   = hdr_free[CLS_NP];
  assign np_data_free_o  = data_free[CLS_NP];
  assign cpl_hdr_free_o  = hdr_free[CLS_CPL];
  assign cpl_data_free_o = data_free[CLS_CPL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q  <= 1'b0;
      in_cls_q  <= '0;
      in_len_q  <= '0;
      in_pois_q <= 1'b0;
      in_hit_q  <= '0;
      stamp_q   <= '0;
      busy_q    <= 1'b0;
      sel_q     <= '0;
      first_q   <= 1'b1;
    end else if (link_reset_i) begin
      in_pkt_q <= 1'b0;
      busy_q   <= 1'b0;
      first_q  <= 1'b1;
    end else begin
      if (in_acc && in_keep) begin
        if (in_eof_i) begin
          in_pkt_q <= 1'b0;
          stamp_q  <= stamp_q + 1'b1;
        end else begin
          in_pkt_q  <= 1'b1;
          in_len_q  <= desc_in.len;
          in_pois_q <= desc_in.poison;
          if (in_new) begin
            in_cls_q <= in_class_i;
            in_hit_q <= in_hit_i;
          end
        end
      end
      // one decision per packet; np_ok_i sampled at the decision
      if (!busy_q) begin
        if (|grant) begin
          busy_q  <= 1'b1;
          sel_q   <= sel_d;
          first_q <= 1'b1;
        end
      end else if (xfer) begin
        first_q <= 1'b0;
        if (out_eof_o) busy_q <= 1'b0;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (link_reset_i || (out_valid_o && $stable(out_data_o) && $stable(out_eof_o))));
  a_r2_gap_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && out_eof_o) |=> !out_valid_o);
  a_r6_np_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !np_ok_i) |=> !(busy_q && sel_q == CLS_NP));
  a_r10_flush_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_reset_i |=> (p_hdr_free_o == 8'(PKTS_PER_CLS) && np_hdr_free_o == 8'(PKTS_PER_CLS)
                      && cpl_hdr_free_o == 8'(PKTS_PER_CLS) && !out_valid_o));
endmodule

// File: tb/rx_pkt_queue_test.sv
`timescale 1ns/1ps
module rx_pkt_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_reset = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_poison = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_class = '0;
  logic [6:0]  in_hit = '0;
  logic        out_ready = 1'b0, np_ok = 1'b1;
  logic        in_ready_o, out_valid_o, out_sof_o, out_eof_o, out_poison_o, out_dsc_o;
  logic [31:0] out_data_o;
  logic [6:0]  out_hit_o;
  logic [1:0]  out_class_o;
  logic [7:0]  p_hf, np_hf, c_hf;
  logic [11:0] p_df, np_df, c_df;

  int n_tests = 0, n_fail = 0;
  logic [43:0] exp_q[$];

  always #2 clk = ~clk;

  rx_pkt_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .link_reset_i(link_reset),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .in_poison_i(in_poison),
    .in_class_i(in_class), .in_hit_i(in_hit),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_eof_o(out_eof_o), .out_poison_o(out_poison_o),
    .out_hit_o(out_hit_o), .out_class_o(out_class_o), .out_dsc_o(out_dsc_o),
    .np_ok_i(np_ok),
    .p_hdr_free_o(p_hf), .p_data_free_o(p_df),
    .np_hdr_free_o(np_hf), .np_data_free_o(np_df),
    .cpl_hdr_free_o(c_hf), .cpl_data_free_o(c_df)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected item: {class, data, sof, eof, poison, hit}
  task automatic push_pkt(input logic [1:0] cls, input int len, input logic [6:0] hit,
                          input bit pois, input logic [31:0] base);
    for (int i = 0; i < len; i++)
      exp_q.push_back({cls, base + 32'(i), i == 0, i == len - 1, pois && (i == len - 1), hit});
  endtask

  task automatic send_pkt(input logic [1:0] cls, input int len, input logic [6:0] hit,
                          input int pidx, input logic [31:0] base, input bit sf);
    bit acc;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = base + 32'(i);
      in_sof = (i == 0); in_eof = (i == len - 1); in_poison = (i == pidx);
      in_class = cls; in_hit = (i == 0) ? hit : ~hit;
      do begin
        @(negedge clk);
        acc = in_ready_o;
        if (sf) check(!out_valid_o, "R1 offered before end word", 64'(out_valid_o), 0);
        @(posedge clk); #1;
      end while (!acc);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_poison = 1'b0;
  endtask

  task automatic wait_drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(posedge clk); t++; end
    check(exp_q.size() == 0, "R2 R5 drain", 64'(exp_q.size()), 0);
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic check_full(input string req);
    check(p_hf == 8 && np_hf == 8 && c_hf == 8, req, {p_hf, np_hf, c_hf}, 24'h080808);
    check(p_df == 16 && np_df == 16 && c_df == 16, req, {p_df, np_df, c_df}, 36'h010010010);
  endtask

  // scoreboard monitor: R2 R3 R4 R5 R7 field compare
  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready) begin
      logic [43:0] act;
      act = {out_class_o, out_data_o, out_sof_o, out_eof_o, out_poison_o, out_hit_o};
      if (exp_q.size() == 0) check(1'b0, "R1 R6 unexpected word", 64'(act), 0);
      else begin
        logic [43:0] e;
        e = exp_q.pop_front();
        check(act == e, "R2 R3 R4 R5 R7 word", 64'(act), 64'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!out_valid_o, "R12 valid", 64'(out_valid_o), 0);
    check(in_ready_o, "R12 ready", 64'(in_ready_o), 1);
    check_full("R12 credits");
    @(posedge clk); #1;

    // R1 R4: store-and-forward, 64-bit region pair hits
    out_ready = 1'b1;
    push_pkt(2'd0, 6, 7'h03, 1'b0, 32'h100);
    send_pkt(2'd0, 6, 7'h03, -1, 32'h100, 1'b1);
    wait_drain();

    // R3: poison on a middle word, then on a single-word packet
    push_pkt(2'd2, 4, 7'h40, 1'b1, 32'h200);
    send_pkt(2'd2, 4, 7'h40, 2, 32'h200, 1'b0);
    push_pkt(2'd1, 1, 7'h10, 1'b1, 32'h300);
    send_pkt(2'd1, 1, 7'h10, 0, 32'h300, 1'b0);
    wait_drain();

    // R5: mixed classes in arrival order
    out_ready = 1'b0;
    push_pkt(2'd0, 3, 7'h01, 1'b0, 32'h400);
    push_pkt(2'd1, 2, 7'h02, 1'b0, 32'h410);
    push_pkt(2'd2, 1, 7'h04, 1'b0, 32'h420);
    push_pkt(2'd0, 2, 7'h08, 1'b0, 32'h430);
    push_pkt(2'd2, 4, 7'h20, 1'b0, 32'h440);
    send_pkt(2'd0, 3, 7'h01, -1, 32'h400, 1'b0);
    send_pkt(2'd1, 2, 7'h02, -1, 32'h410, 1'b0);
    send_pkt(2'd2, 1, 7'h04, -1, 32'h420, 1'b0);
    send_pkt(2'd0, 2, 7'h08, -1, 32'h430, 1'b0);
    send_pkt(2'd2, 4, 7'h20, -1, 32'h440, 1'b0);
    out_ready = 1'b1;
    wait_drain();

    // R8 R9: credits held until the packet leaves
    out_ready = 1'b0;
    push_pkt(2'd0, 5, 7'h00, 1'b0, 32'h500);
    push_pkt(2'd1, 3, 7'h00, 1'b0, 32'h510);
    send_pkt(2'd0, 5, 7'h00, -1, 32'h500, 1'b0);
    send_pkt(2'd1, 3, 7'h00, -1, 32'h510, 1'b0);
    @(negedge clk);
    check(p_hf == 7, "R8 posted hdr", 64'(p_hf), 7);
    check(np_hf == 7, "R8 non-posted hdr", 64'(np_hf), 7);
    check(p_df == 14, "R9 posted data", 64'(p_df), 14);
    check(np_df == 15, "R9 non-posted data", 64'(np_df), 15);
    check(c_hf == 8 && c_df == 16, "R8 R9 completion untouched", {c_hf, c_df}, 20'h08010);
    @(posedge clk); #1 out_ready = 1'b1;
    wait_drain();
    check_full("R8 R9 credits returned");

    // R6: non-posted held while np_ok is low
    out_ready = 1'b0; np_ok = 1'b0;
    send_pkt(2'd1, 2, 7'h01, -1, 32'h600, 1'b0);
    send_pkt(2'd0, 3, 7'h02, -1, 32'h610, 1'b0);
    send_pkt(2'd2, 2, 7'h04, -1, 32'h620, 1'b0);
    send_pkt(2'd1, 1, 7'h08, -1, 32'h630, 1'b0);
    push_pkt(2'd0, 3, 7'h02, 1'b0, 32'h610);
    push_pkt(2'd2, 2, 7'h04, 1'b0, 32'h620);
    out_ready = 1'b1;
    wait_drain();
    repeat (3) begin
      @(negedge clk);
      check(!out_valid_o, "R6 non-posted offered while blocked", 64'(out_valid_o), 0);
    end
    @(posedge clk); #1;
    push_pkt(2'd1, 2, 7'h01, 1'b0, 32'h600);
    push_pkt(2'd1, 1, 7'h08, 1'b0, 32'h630);
    np_ok = 1'b1;
    wait_drain();

    // R11: full posted storage stalls the input
    out_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      push_pkt(2'd0, 16, 7'h05, 1'b0, 32'h700 + 32'(k * 16));
      send_pkt(2'd0, 16, 7'h05, -1, 32'h700 + 32'(k * 16), 1'b0);
    end
    @(negedge clk);
    check(p_df == 0, "R9 R11 posted data full", 64'(p_df), 0);
    check(p_hf == 4, "R8 posted hdr", 64'(p_hf), 4);
    @(posedge clk); #1;
    push_pkt(2'd0, 2, 7'h05, 1'b0, 32'h800);
    fork
      send_pkt(2'd0, 2, 7'h05, -1, 32'h800, 1'b0);
      begin
        repeat (3) @(negedge clk);
        check(!in_ready_o, "R11 ready while full", 64'(in_ready_o), 0);
        @(posedge clk); #1 out_ready = 1'b1;
      end
    join
    wait_drain();

    // R11: packet slots exhausted by single-word completions
    out_ready = 1'b0;
    for (int k = 0; k < 8; k++) begin
      push_pkt(2'd2, 1, 7'h00, 1'b0, 32'h900 + 32'(k));
      send_pkt(2'd2, 1, 7'h00, -1, 32'h900 + 32'(k), 1'b0);
    end
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_class = 2'd2; in_data = 32'h9FF;
    @(negedge clk);
    check(!in_ready_o, "R11 ready with no slot", 64'(in_ready_o), 0);
    check(c_hf == 0, "R8 completion hdr", 64'(c_hf), 0);
    @(posedge clk); #1 in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    out_ready = 1'b1;
    wait_drain();

    // R10: link reset discards and flags the offered packet
    out_ready = 1'b0;
    send_pkt(2'd0, 3, 7'h01, -1, 32'hA00, 1'b0);
    send_pkt(2'd2, 2, 7'h02, -1, 32'hA10, 1'b0);
    repeat (2) @(posedge clk); #1;
    @(negedge clk);
    check(out_valid_o, "R10 packet offered before reset", 64'(out_valid_o), 1);
    @(posedge clk); #1 link_reset = 1'b1;
    @(negedge clk);
    check(out_dsc_o, "R10 discontinue", 64'(out_dsc_o), 1);
    check(!out_valid_o && !in_ready_o, "R10 valid/ready during reset",
          {out_valid_o, in_ready_o}, 0);
    @(posedge clk); #1 link_reset = 1'b0;
    out_ready = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(!out_valid_o && !out_dsc_o, "R10 queue empty", {out_valid_o, out_dsc_o}, 0);
    end
    check_full("R10 credits full");
    @(posedge clk); #1;
    push_pkt(2'd1, 2, 7'h7F, 1'b0, 32'hB00);
    send_pkt(2'd1, 2, 7'h7F, -1, 32'hB00, 1'b0);
    wait_drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule